// File: doc/BRIEF.md
# Logic Cell Test Sequence Generator

This block sequences the universal test of a lookup-table logic cell. The cell has a K-input truth table, two select bits and a D flip-flop. Once started, the block steps through a fixed schedule of 2K+4 test steps. For each step it first shifts out a configuration word for the cell. It then pulses a load strobe and plays the ordered stimulus for that step on the data inputs and on the auxiliary input. Alongside the stimulus it produces the output that a fault-free chain of cells should give.

The number of cells wired in series, NCELL, is a parameter. It sets how far the expected response trails the stimulus when the flip-flop path is selected. It also sets whether a chain of inverting cells ends up inverted. Comparing the expected stream with the real cell outputs, and deciding which cell is faulty, is left to the logic that consumes these outputs.

Top module: `cell_test_seq`

## Requirements
- R1: After reset, and whenever no schedule is running, `step_idx` is 0 and `cfg_shift`, `cfg_load`, `stim_valid`, `exp_valid` and `done` are all low. An asynchronous reset during a run returns the block to this state at once.
- R2: A `start` pulse seen while idle runs steps 1 to 2K+4 in order. `step_idx` shows the current step. Each step has four phases back to back with no gap: CFG_W = 2^K+2 cycles with `cfg_shift` high, one cycle with `cfg_load` high, L stimulus cycles with `stim_valid` high, and D flush cycles. D is NCELL for flip-flop steps and 0 otherwise.
- R3: The configuration word is sent MSB first as {sel_b, sel_a, T[2^K-1], ..., T[0]}. T[a] is the cell output for input address a. For steps 1..K, T[a] = a[i-1]. For steps K+1..2K, T[a] = NOT a[i-K-1]. For steps 2K+1..2K+4, T[a] = a[0].
- R4: The select bits are set as follows. sel_a (table output feeds the flip-flop) is 1 in every step except 2K+4. sel_b (output taken from the flip-flop) is 1 only in steps 2K+1, 2K+2 and 2K+4.
- R5: In steps 1..2K there are L = 2^K+1 stimulus cycles. `stim_x` counts 0, 1, ..., 2^K-1 and then returns to 0. `stim_c` is 0 throughout.
- R6: Step 2K+1 has L = 6 stimulus cycles. `stim_x` is held at 0, and `stim_c` follows 0, 0, 0, 1, 1, 0.
- R7: Steps 2K+2..2K+4 have L = 2^K+1 stimulus cycles. `stim_x` counts 0 .. 2^K-1 and then repeats all-ones. In step 2K+2, `stim_c` alternates 0, 1, 0, 1, ... starting from 0. In the other two steps it is 0.
- R8: The expected bit for stimulus x is computed as follows. In steps 1..K it is x[i-1]. In steps K+1..2K it is x[i-K-1] XOR (NCELL odd). In steps 2K+1..2K+4 it is x[0].
- R9: In flip-flop steps, the expected bit for the stimulus of stimulus cycle p is shown with `exp_valid` high in cycle p+NCELL, counted from the first stimulus cycle. In all other steps it is shown in cycle p itself. `exp_valid` is high for exactly L cycles per step.
- R10: `done` is high for exactly one cycle, straight after the last flush or stimulus cycle of step 2K+4. The block is idle in the next cycle.
- R11: `start` has no effect while a schedule is running or while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the schedule when idle |
| cfg_bit | output | 1 | Serial configuration data, MSB first |
| cfg_shift | output | 1 | cfg_bit holds a valid bit |
| cfg_load | output | 1 | One-cycle strobe to apply the shifted word |
| stim_x | output | K | Stimulus on the cell data inputs |
| stim_c | output | 1 | Stimulus on the cell auxiliary input |
| stim_valid | output | 1 | Stimulus cycle |
| exp_bit | output | 1 | Expected fault-free chain output |
| exp_valid | output | 1 | exp_bit is meaningful |
| step_idx | output | clog2(2K+5) | Current step, 1..2K+4; 0 when idle |
| done | output | 1 | One-cycle end-of-schedule pulse |

## Verification
The bench builds the block with K=3 and NCELL=3. This gives eight-entry truth tables, so each step index picks a distinct input bit, and ten steps in all. The odd chain length turns the complement steps' expected bit into the inverted input, and the 3-cycle lag in the flip-flop steps is shorter than their stimulus, so the valid window overlaps the stimulus and then runs into the flush. Random start pulses are injected during configuration shifting and in the `done` cycle, and a reset lands at a random point mid-schedule.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_LOAD,
    ST_STIM,
    ST_FLUSH,
    ST_DONE
  } cts_state_e;

  localparam logic [1:0] FN_DIRECT = 2'd0;
  localparam logic [1:0] FN_COMPL  = 2'd1;
  localparam logic [1:0] FN_BIT0   = 2'd2;
endpackage

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int CNT_W  = 4,
  parameter int CFG_W  = 6,
  parameter int LAST   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  stim_len,
  input  logic [CNT_W-1:0]  flush_len,
  output logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cnt,
  output logic              cfg_shift,
  output logic              cfg_load,
  output logic              stim_on,
  output logic              done_p,
  output logic              busy
);
  cts_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_end;
  logic              upd_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    step_d   = step_q;
    step_end = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_CFG;
        cnt_d  = '0;
        step_d = STEP_W'(1);
      end
      ST_CFG: if (cnt_q == CNT_W'(CFG_W - 1)) begin
        st_d  = ST_LOAD;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_LOAD: begin
        st_d  = ST_STIM;
        cnt_d = '0;
      end
      ST_STIM: if (cnt_q == stim_len - 1'b1) begin
        if (flush_len == '0) step_end = 1'b1;
        else begin
          st_d  = ST_FLUSH;
          cnt_d = '0;
        end
      end else cnt_d = cnt_q + 1'b1;
      ST_FLUSH: if (cnt_q == flush_len - 1'b1) step_end = 1'b1;
                else cnt_d = cnt_q + 1'b1;
      ST_DONE: begin
        st_d   = ST_IDLE;
        step_d = '0;
      end
      default: st_d = ST_IDLE;
    endcase
    if (step_end) begin
      cnt_d = '0;
      if (step_q == STEP_W'(LAST)) st_d = ST_DONE;
      else begin
        st_d   = ST_CFG;
        step_d = step_q + 1'b1;
      end
    end
  end

  assign upd_en = (st_q != ST_IDLE) | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      step_q <= step_d;
    end
  end

  assign step      = step_q;
  assign cnt       = cnt_q;
  assign cfg_shift = (st_q == ST_CFG);
  assign cfg_load  = (st_q == ST_LOAD);
  assign stim_on   = (st_q == ST_STIM);
  assign done_p    = (st_q == ST_DONE);
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/cts_pattern.sv
module cts_pattern
  import cts_pkg::*;
#(
  parameter int K      = 2,
  parameter int NCELL  = 4,
  parameter int STEP_W = 4,
  parameter int CNT_W  = 4,
  localparam int NLUT  = 1 << K,
  localparam int CFG_W = NLUT + 2
) (
  input  logic [STEP_W-1:0] step,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [K-1:0]      px,
  output logic              pc,
  output logic              pe,
  output logic              ff_path,
  output logic [CNT_W-1:0]  stim_len,
  output logic [CNT_W-1:0]  flush_len
);
  localparam logic CHAIN_INV = (NCELL % 2) == 1;
  localparam int   S_HOLD = 2 * K + 1;
  localparam int   S_TOG  = 2 * K + 2;
  localparam int   S_CAP  = 2 * K + 4;

  int          s, t, j;
  logic [1:0]  fn;
  logic        sel_a;
  logic [NLUT-1:0] lut;

  always_comb begin
    s = int'(step);
    t = int'(cnt);
    if (s >= 1 && s <= K) begin
      fn = FN_DIRECT;
      j  = s - 1;
    end else if (s > K && s <= 2 * K) begin
      fn = FN_COMPL;
      j  = s - K - 1;
    end else begin
      fn = FN_BIT0;
      j  = 0;
    end

    for (int a = 0; a < NLUT; a++) begin
      logic [K-1:0] av;
      av     = K'(a);
      lut[a] = (fn == FN_COMPL) ? ~av[j] : av[j];
    end
    sel_a    = (s != S_CAP);
    ff_path  = (s == S_HOLD) || (s == S_TOG) || (s == S_CAP);
    cfg_word = {ff_path, sel_a, lut};

    if (s == S_HOLD)   px = '0;
    else if (t < NLUT) px = K'(t);
    else if (s <= 2*K) px = '0;
    else               px = '1;

    if (s == S_HOLD)     pc = (t == 3) || (t == 4);
    else if (s == S_TOG) pc = cnt[0];
    else                 pc = 1'b0;

    pe        = px[j] ^ ((fn == FN_COMPL) & CHAIN_INV);
    stim_len  = (s == S_HOLD) ? CNT_W'(6) : CNT_W'(NLUT + 1);
    flush_len = ff_path ? CNT_W'(NCELL) : '0;
  end
endmodule

// File: rtl/cts_resp_delay.sv
module cts_resp_delay #(
  parameter int NCELL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic use_dly,
  input  logic in_v,
  input  logic in_b,
  output logic out_v,
  output logic out_b
);
  logic [NCELL-1:0] v_q, v_d, b_q, b_d;
  logic             in_v_ff;

  assign in_v_ff = in_v & use_dly;

  generate
    if (NCELL == 1) begin : g_single
      always_comb begin
        v_d = in_v_ff;
        b_d = in_b;
      end
    end else begin : g_chain
      always_comb begin
        v_d = {v_q[NCELL-2:0], in_v_ff};
        b_d = {b_q[NCELL-2:0], in_b};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      b_q <= '0;
    end else if (en) begin
      v_q <= v_d;
      b_q <= b_d;
    end
  end

  assign out_v = use_dly ? v_q[NCELL-1] : in_v;
  assign out_b = use_dly ? b_q[NCELL-1] : in_b;
endmodule

// File: rtl/cell_test_seq.sv
module cell_test_seq
  import cts_pkg::*;
#(
  parameter int K     = 2,
  parameter int NCELL = 4,
  localparam int STEP_W = $clog2(2 * K + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cfg_bit,
  output logic              cfg_shift,
  output logic              cfg_load,
  output logic [K-1:0]      stim_x,
  output logic              stim_c,
  output logic              stim_valid,
  output logic              exp_bit,
  output logic              exp_valid,
  output logic [STEP_W-1:0] step_idx,
  output logic              done
);
  localparam int NLUT     = 1 << K;
  localparam int CFG_W    = NLUT + 2;
  localparam int LAST     = 2 * K + 4;
  localparam int STIM_MAX = (NLUT + 1 > 6) ? NLUT + 1 : 6;
  localparam int CNT_A    = (CFG_W > STIM_MAX) ? CFG_W : STIM_MAX;
  localparam int CNT_MAX  = (CNT_A > NCELL) ? CNT_A : NCELL;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt, stim_len, flush_len;
  logic [CFG_W-1:0] cfg_word;
  logic [K-1:0]     px;
  logic             pc, pe, ff_path, busy;

  cts_ctrl #(.STEP_W(STEP_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .LAST(LAST)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stim_len(stim_len), .flush_len(flush_len),
    .step(step_idx), .cnt(cnt),
    .cfg_shift(cfg_shift), .cfg_load(cfg_load), .stim_on(stim_valid),
    .done_p(done), .busy(busy)
  );

  cts_pattern #(.K(K), .NCELL(NCELL), .STEP_W(STEP_W), .CNT_W(CNT_W)) pat_i (
    .step(step_idx), .cnt(cnt), .cfg_word(cfg_word),
    .px(px), .pc(pc), .pe(pe), .ff_path(ff_path),
    .stim_len(stim_len), .flush_len(flush_len)
  );

  cts_resp_delay #(.NCELL(NCELL)) dly_i (
    .clk(clk), .rst_n(rst_n), .en(busy), .use_dly(ff_path),
    .in_v(stim_valid), .in_b(stim_valid & pe),
    .out_v(exp_valid), .out_b(exp_bit)
  );

  always_comb begin
    cfg_bit = 1'b0;
    if (cfg_shift && int'(cnt) < CFG_W) cfg_bit = cfg_word[CFG_W-1-int'(cnt)];
  end

  assign stim_x = stim_valid ? px : '0;
  assign stim_c = stim_valid & pc;
endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
  parameter int K      = 2,
  parameter int NCELL  = 4,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cfg_shift,
  input logic              cfg_load,
  input logic              stim_c,
  input logic              stim_valid,
  input logic              exp_valid,
  input logic [STEP_W-1:0] step_idx,
  input logic              done
);
  localparam int LAST = 2 * K + 4;
  logic ff_step, idle_n, plain_step;

  assign ff_step    = (int'(step_idx) == 2*K+1) || (int'(step_idx) == 2*K+2) ||
                      (int'(step_idx) == LAST);
  assign idle_n     = (step_idx != '0);
  assign plain_step = (int'(step_idx) >= 1) && (int'(step_idx) <= 2*K);

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_shift, cfg_load, stim_valid, done}));
  assert_load_after_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> $past(cfg_shift));
  assert_load_step_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> $stable(step_idx));
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_idx) <= LAST);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_n |-> !(cfg_shift || cfg_load || stim_valid || exp_valid || done));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && (step_idx == '0));
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !cfg_shift);
  assert_comb_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_n && !ff_step) |-> (exp_valid == stim_valid));
  assert_ff_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_step && $rose(stim_valid)) |-> !exp_valid);
  assert_c_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && stim_valid) |-> !stim_c);
endmodule

bind cell_test_seq cts_checker #(.K(K), .NCELL(NCELL), .STEP_W(STEP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_shift(cfg_shift),
  .cfg_load(cfg_load), .stim_c(stim_c), .stim_valid(stim_valid),
  .exp_valid(exp_valid), .step_idx(step_idx), .done(done)
);

// File: tb/cell_test_seq_tb_top.sv
`timescale 1ns/1ps
module cell_test_seq_tb_top;
  localparam int K      = 3;
  localparam int NCELL  = 3;
  localparam int STEP_W = $clog2(2 * K + 5);
  localparam int NLUT   = 1 << K;
  localparam int CFG_W  = NLUT + 2;
  localparam int LAST   = 2 * K + 4;

  logic clk = 1'b0;
  logic rst_n, start;
  logic cfg_bit, cfg_shift, cfg_load, stim_c, stim_valid, exp_bit, exp_valid, done;
  logic [K-1:0] stim_x;
  logic [STEP_W-1:0] step_idx;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cell_test_seq #(.K(K), .NCELL(NCELL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_bit(cfg_bit),
    .cfg_shift(cfg_shift), .cfg_load(cfg_load), .stim_x(stim_x),
    .stim_c(stim_c), .stim_valid(stim_valid), .exp_bit(exp_bit),
    .exp_valid(exp_valid), .step_idx(step_idx), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      $display("FAIL R2 watchdog expired: actual=%0d expected=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit is_ff(input int s);
    return (s == 2*K+1) || (s == 2*K+2) || (s == 2*K+4);
  endfunction

  function automatic int slen(input int s);
    return (s == 2*K+1) ? 6 : NLUT + 1;
  endfunction

  function automatic int sdly(input int s);
    return is_ff(s) ? NCELL : 0;
  endfunction

  function automatic int sel_bit(input int s);
    return (s <= K) ? s - 1 : (s <= 2*K) ? s - K - 1 : 0;
  endfunction

  function automatic logic [CFG_W-1:0] exp_word(input int s);
    logic [CFG_W-1:0] w;
    for (int a = 0; a < NLUT; a++) begin
      bit v;
      v = ((a >> sel_bit(s)) & 1) != 0;
      w[a] = (s > K && s <= 2*K) ? !v : v;
    end
    w[CFG_W-1] = is_ff(s);
    w[CFG_W-2] = (s != 2*K+4);
    return w;
  endfunction

  function automatic int pat_x(input int s, input int t);
    if (s == 2*K+1) return 0;
    if (t < NLUT) return t;
    return (s <= 2*K) ? 0 : NLUT - 1;
  endfunction

  function automatic int pat_c(input int s, input int t);
    if (s == 2*K+1) return (t == 3 || t == 4) ? 1 : 0;
    if (s == 2*K+2) return t % 2;
    return 0;
  endfunction

  function automatic int fval(input int s, input int xv);
    int b;
    b = (xv >> sel_bit(s)) & 1;
    if (s > K && s <= 2*K && (NCELL % 2) == 1) b = 1 - b;
    return b;
  endfunction

  function automatic bit quiet();
    return step_idx == '0 && !cfg_shift && !cfg_load && !stim_valid &&
           !exp_valid && !done;
  endfunction

  task automatic run_seq(input bit noise);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int s = 1; s <= LAST; s++) begin
      int L, D, ce, xe, ve, be;
      logic [CFG_W-1:0] w, ew;
      L = slen(s); D = sdly(s); ce = 0; xe = 0; ve = 0; be = 0;
      ew = exp_word(s);
      chk(int'(step_idx) == s, "R2", "step index", int'(step_idx), s);
      for (int b = 0; b < CFG_W; b++) begin
        if (!cfg_shift || stim_valid || cfg_load) ce++;
        w = {w[CFG_W-2:0], cfg_bit};
        if (noise) start = 1'($urandom_range(0, 1));
        @(negedge clk);
      end
      start = 1'b0;
      chk(ce == 0, noise ? "R11" : "R2", "shift phase errors", ce, 0);
      chk(w[NLUT-1:0] == ew[NLUT-1:0], "R3", "truth table", int'(w[NLUT-1:0]),
          int'(ew[NLUT-1:0]));
      chk(w[CFG_W-1 -: 2] == ew[CFG_W-1 -: 2], "R4", "select bits",
          int'(w[CFG_W-1 -: 2]), int'(ew[CFG_W-1 -: 2]));
      chk(cfg_load && !cfg_shift && !stim_valid, "R2", "load strobe", int'(cfg_load), 1);
      @(negedge clk);
      for (int p = 0; p < L + D; p++) begin
        if (p < L) begin
          if (!stim_valid || int'(stim_x) != pat_x(s, p) || int'(stim_c) != pat_c(s, p)) xe++;
        end else if (stim_valid) xe++;
        if (exp_valid != (p >= D)) ve++;
        else if (p >= D && int'(exp_bit) != fval(s, pat_x(s, p - D))) be++;
        @(negedge clk);
      end
      if (s <= 2*K)        chk(xe == 0, "R5", "stimulus mismatches", xe, 0);
      else if (s == 2*K+1) chk(xe == 0, "R6", "stimulus mismatches", xe, 0);
      else                 chk(xe == 0, "R7", "stimulus mismatches", xe, 0);
      chk(be == 0, "R8", "expected bit mismatches", be, 0);
      chk(ve == 0, "R9", "valid timing mismatches", ve, 0);
    end
    chk(done && !cfg_shift, "R10", "done pulse", int'(done), 1);
    if (noise) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(quiet(), noise ? "R11" : "R10", "idle after done", int'(step_idx), 0);
  endtask

  initial begin
    int gap, qe;
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(quiet(), "R1", "outputs in reset", int'(step_idx), 0);
    rst_n = 1'b1;
    gap = $urandom_range(3, 12); qe = 0;
    repeat (gap) begin
      @(negedge clk);
      if (!quiet()) qe++;
    end
    chk(qe == 0, "R1", "idle without start", qe, 0);

    run_seq(1'b0);
    repeat ($urandom_range(0, 6)) @(negedge clk);
    run_seq(1'b1);

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat ($urandom_range(5, 120)) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(quiet(), "R1", "mid-run reset", int'(step_idx), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(quiet(), "R1", "idle after reset release", int'(step_idx), 0);

    repeat ($urandom_range(1, 8)) @(negedge clk);
    run_seq(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule